// File: doc/BRIEF.md
# Descriptor-Loaded Memory Copy Channel

This block is a single memory-to-memory copy engine. It does not hold the parameters of a transfer in its own registers. Software places a four-word descriptor in memory, writes the descriptor's byte address into the channel, and then sets the run bit. The channel reads the descriptor through its memory master port. It then moves data one 32-bit word at a time from the source to the destination. When the byte count is used up, it drops the run bit. If the descriptor asked for an interrupt, the channel also latches a done flag that drives its interrupt pin. Software clears that flag by writing a one to its bit.

The register side is a minimal write strobe plus an offset, with a combinational read. The memory side uses a request/acknowledge handshake that carries one word per access. The sequencer has five states. IDLE waits for a start. LOAD reads the descriptor words at +0, +4, +8 and +12. PULL reads one source word. PUSH writes that word to the destination. FINISH lasts one cycle and retires the transfer. The transitions are:
- IDLE to LOAD on a start.
- LOAD to LOAD after each of the first three descriptor acknowledges.
- LOAD to FINISH on the fourth acknowledge if the length is zero, otherwise LOAD to PULL.
- PULL to PUSH on its acknowledge.
- PUSH to PULL while more than four bytes remain, otherwise PUSH to FINISH.
- FINISH to IDLE always.

Top module: `cbdma_channel`

## Requirements
- R1: After reset, the status word at offset 0x0 reads zero, the interrupt pin is low and no memory request is issued.
- R2: Writing a word with bit 0 set to offset 0x0 while the channel is idle starts it. The channel first reads four words, in order, at the descriptor address held at offset 0x4, plus 0, 4, 8 and 12. These words are the mode word, the source address, the destination address and the byte length.
- R3: If bit 8 of the mode word is set, the source address advances by 4 after each word read. If the bit is clear, every read uses the same source address.
- R4: If bit 4 of the mode word is set, the destination address advances by 4 after each word written. If the bit is clear, every write uses the same destination address.
- R5: A transfer of L bytes moves ceil(L/4) words. Each source read completes before the write of the same data is issued, and the written word equals the word read.
- R6: A length of zero ends the transfer right after the descriptor is read. No data access takes place.
- R7: Bit 0 of the status word reads 1 while the channel is working and returns to 0 by itself after the last write.
- R8: If bit 0 of the mode word is set, completion sets bit 2 of the status word and raises the interrupt pin. If the bit is clear, neither changes.
- R9: Writing offset 0x0 with bit 2 set clears the done flag and lowers the interrupt pin. A write with bit 2 clear leaves the flag as it is.
- R10: Writes to the descriptor address register at offset 0x4 are ignored while bit 0 of the status word is 1. Its read-back value does not change.
- R11: A memory request stays asserted, with its address and direction held steady, until it is acknowledged.
- R12: The interrupt pin always equals bit 2 of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that mem_ack is pulsed only while a request is pending and never in two consecutive cycles. They also assume that register writes come as single-cycle strobes. The bench memory model acknowledges each request after a fixed two-cycle wait and then deasserts for one cycle. It drives register strobes at falling edges, one cycle at a time. Descriptors and buffers are kept inside the modelled 512-byte space, so no address wraps.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    localparam int ST_ACTIVE_BIT = 0;
    localparam int ST_DONE_BIT   = 2;

    localparam int MODE_IRQ_BIT  = 0;
    localparam int MODE_DINC_BIT = 4;
    localparam int MODE_SINC_BIT = 8;

    localparam int OFF_STATUS = 'h0;
    localparam int OFF_DESC   = 'h4;

    typedef enum logic [2:0] {
        IDLE,
        LOAD,
        PULL,
        PUSH,
        FINISH
    } seq_state_t;

    typedef struct packed {
        logic irq_en;
        logic dst_inc;
        logic src_inc;
    } mode_t;
endpackage

// File: rtl/cbdma_regs.sv
module cbdma_regs
    import cbdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                busy,
    input  logic                irq_set,
    output logic                start,
    output logic [ADDR_W-1:0]   desc_addr,
    output logic                done_flag
);
    localparam logic [REG_AW-1:0] A_STATUS = REG_AW'(OFF_STATUS);
    localparam logic [REG_AW-1:0] A_DESC   = REG_AW'(OFF_DESC);

    logic wr_status, wr_desc;
    assign wr_status = reg_we && (reg_addr == A_STATUS);
    assign wr_desc   = reg_we && (reg_addr == A_DESC);
    assign start     = wr_status && reg_wdata[ST_ACTIVE_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_addr <= '0;
            done_flag <= 1'b0;
        end else begin
            if (wr_desc && !busy)
                desc_addr <= reg_wdata[ADDR_W-1:0];
            if (irq_set)
                done_flag <= 1'b1;
            else if (wr_status && reg_wdata[ST_DONE_BIT])
                done_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATUS) begin
            reg_rdata[ST_ACTIVE_BIT] = busy;
            reg_rdata[ST_DONE_BIT]   = done_flag;
        end else if (reg_addr == A_DESC) begin
            reg_rdata = WORD_W'(desc_addr);
        end
    end
endmodule

// File: rtl/cbdma_seq.sv
module cbdma_seq
    import cbdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   desc_addr,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                irq_set
);
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
    localparam logic [WORD_W-1:0] LSTEP = WORD_W'(WORD_BYTES);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DESC_WORDS - 1);

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    mode_t             mode_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [WORD_W-1:0] left_q, data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:   if (start) state_d = LOAD;
            LOAD:   if (mem_ack && idx_q == LAST_IDX)
                        state_d = (mem_rdata == '0) ? FINISH : PULL;
            PULL:   if (mem_ack) state_d = PUSH;
            PUSH:   if (mem_ack) state_d = (left_q <= LSTEP) ? FINISH : PULL;
            FINISH: state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mode_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state_q)
                IDLE: idx_q <= '0;
                LOAD: if (mem_ack) begin
                    idx_q <= idx_q + 1'b1;
                    unique case (idx_q)
                        2'd0: begin
                            mode_q.irq_en  <= mem_rdata[MODE_IRQ_BIT];
                            mode_q.dst_inc <= mem_rdata[MODE_DINC_BIT];
                            mode_q.src_inc <= mem_rdata[MODE_SINC_BIT];
                        end
                        2'd1: src_q  <= mem_rdata[ADDR_W-1:0];
                        2'd2: dst_q  <= mem_rdata[ADDR_W-1:0];
                        default: left_q <= mem_rdata;
                    endcase
                end
                PULL: if (mem_ack) begin
                    data_q <= mem_rdata;
                    if (mode_q.src_inc) src_q <= src_q + STEP;
                end
                PUSH: if (mem_ack) begin
                    if (mode_q.dst_inc) dst_q <= dst_q + STEP;
                    if (left_q > LSTEP) left_q <= left_q - LSTEP;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_q;
        mem_wdata = data_q;
        busy      = (state_q != IDLE);
        irq_set   = 1'b0;
        unique case (state_q)
            LOAD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'({idx_q, 2'b00});
            end
            PULL: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            PUSH: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            FINISH: irq_set = mode_q.irq_en;
            default: ;
        endcase
    end
endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
    import cbdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_ack,
    input  logic [31:0]         mem_rdata,
    output logic                irq
);
    logic              busy, irq_set, start, done_flag;
    logic [ADDR_W-1:0] desc_addr;

    cbdma_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .irq_set(irq_set), .start(start), .desc_addr(desc_addr),
        .done_flag(done_flag)
    );

    cbdma_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .irq_set(irq_set)
    );

    assign irq = done_flag;
endmodule

// File: rtl/cbdma_channel_checks.sv
module cbdma_channel_checks #(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              irq,
    input logic              busy,
    input logic              irq_set,
    input logic [ADDR_W-1:0] desc_addr
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq && !mem_req));

    assert_irq_rises_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_set));

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0 && reg_wdata[2] && !irq_set) |=> !irq);

    assert_desc_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(desc_addr));

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind cbdma_channel cbdma_channel_checks #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_checks (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq), .busy(busy),
    .irq_set(irq_set), .desc_addr(desc_addr)
);

// File: tb/cbdma_channel_test.sv
`timescale 1ns/1ps
module cbdma_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    cbdma_channel uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model: 128 words, acknowledge after a two-cycle wait
    logic [31:0] mem [128];
    logic [31:0] log_a [128];
    logic        log_w [128];
    int log_n = 0;
    int hs_bad = 0;
    int wait_cnt = 0;
    logic        pw = 1'b0;
    logic [31:0] pa = '0;

    always @(posedge clk) begin
        if (pw && (!mem_req || mem_addr != pa)) hs_bad <= hs_bad + 1;
        pw <= mem_req && !mem_ack;
        pa <= mem_addr;
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 1) begin
                wait_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[8:2]];
                if (log_n < 128) begin
                    log_a[log_n] <= mem_addr;
                    log_w[log_n] <= mem_we;
                end
                log_n <= log_n + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_read(4'h0, s);
            if (!s[0]) break;
        end
    endtask

    task automatic setup_desc(input logic [31:0] cb, input logic [31:0] mode,
                              input logic [31:0] src, input logic [31:0] dst, input logic [31:0] len);
        mem[cb[8:2]]     = mode;
        mem[cb[8:2] + 1] = src;
        mem[cb[8:2] + 2] = dst;
        mem[cb[8:2] + 3] = len;
    endtask

    task automatic check_fetch(input int base, input logic [31:0] cb);
        int bad = 0;
        for (int k = 0; k < 4; k++)
            if (log_a[base+k] != cb + 32'(4*k) || log_w[base+k]) bad++;
        check(bad == 0, "R2 descriptor fetch order", 32'(bad), 0);
    endtask

    task automatic t_reset();
        logic [31:0] s;
        reg_read(4'h0, s);
        check(s == 0, "R1 status after reset", s, 0);
        check(irq == 0, "R1 irq after reset", {31'b0, irq}, 0);
        check(mem_req == 0, "R1 no request after reset", {31'b0, mem_req}, 0);
    endtask

    task automatic t_inc_copy();
        logic [31:0] s;
        int base, bad;
        setup_desc(32'h100, 32'h111, 32'h20, 32'h40, 32);
        for (int w = 0; w < 8; w++) mem[8 + w] = (w == 0) ? 32'h1234_5678 : ~32'h1234_5678 ^ 32'(w);
        for (int w = 0; w < 8; w++) mem[16 + w] = 32'hDEAD_0000;
        reg_write(4'h4, 32'h100);
        base = log_n;
        reg_write(4'h0, 32'h1);
        reg_read(4'h0, s);
        check(s[0] == 1'b1, "R7 active while running", s, 1);
        wait_idle();
        check_fetch(base, 32'h100);
        bad = 0;
        for (int w = 0; w < 8; w++) begin
            if (log_a[base+4+2*w] != 32'h20 + 32'(4*w) || log_w[base+4+2*w]) bad++;
        end
        check(bad == 0, "R3 source steps by 4", 32'(bad), 0);
        bad = 0;
        for (int w = 0; w < 8; w++) begin
            if (log_a[base+5+2*w] != 32'h40 + 32'(4*w) || !log_w[base+5+2*w]) bad++;
        end
        check(bad == 0, "R4 destination steps by 4, write after read", 32'(bad), 0);
        bad = 0;
        for (int w = 0; w < 8; w++) if (mem[16 + w] != mem[8 + w]) bad++;
        check(bad == 0, "R5 copied data", 32'(bad), 0);
        check(log_n - base == 20, "R5 access count", 32'(log_n - base), 20);
        reg_read(4'h0, s);
        check(s == 32'h4, "R7 R8 status after finish", s, 32'h4);
        check(irq == 1'b1, "R12 irq follows flag", {31'b0, irq}, 1);
        reg_write(4'h0, 32'h0);
        reg_read(4'h0, s);
        check(s == 32'h4, "R9 write without bit 2 keeps flag", s, 32'h4);
        reg_write(4'h0, 32'h4);
        reg_read(4'h0, s);
        check(s == 32'h0, "R9 clear flag", s, 0);
        check(irq == 1'b0, "R9 R12 irq low after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_fixed();
        logic [31:0] s;
        int base, bad;
        setup_desc(32'h140, 32'h000, 32'h60, 32'h80, 12);
        mem[24] = 32'hCAFE_F00D; mem[25] = 32'h1111_1111;
        mem[32] = 32'h0; mem[33] = 32'h5555_5555;
        reg_write(4'h4, 32'h140);
        base = log_n;
        reg_write(4'h0, 32'h1);
        wait_idle();
        check_fetch(base, 32'h140);
        check(log_n - base == 10, "R5 three words for 12 bytes", 32'(log_n - base), 10);
        bad = 0;
        for (int w = 0; w < 3; w++) begin
            if (log_a[base+4+2*w] != 32'h60) bad++;
            if (log_a[base+5+2*w] != 32'h80) bad++;
        end
        check(bad == 0, "R3 R4 addresses held", 32'(bad), 0);
        check(mem[32] == 32'hCAFE_F00D, "R5 fixed dest data", mem[32], 32'hCAFE_F00D);
        check(mem[33] == 32'h5555_5555, "R4 next dest word untouched", mem[33], 32'h5555_5555);
        reg_read(4'h0, s);
        check(s == 32'h0, "R8 no flag without enable", s, 0);
        check(irq == 1'b0, "R8 irq low without enable", {31'b0, irq}, 0);
    endtask

    task automatic t_zero_len();
        logic [31:0] s;
        int base;
        setup_desc(32'h160, 32'h111, 32'h20, 32'h40, 0);
        reg_write(4'h4, 32'h160);
        base = log_n;
        reg_write(4'h0, 32'h1);
        wait_idle();
        check_fetch(base, 32'h160);
        check(log_n - base == 4, "R6 zero length moves nothing", 32'(log_n - base), 4);
        reg_read(4'h0, s);
        check(s == 32'h4, "R6 R8 completes with flag", s, 32'h4);
        check(irq == 1'b1, "R12 irq follows flag", {31'b0, irq}, 1);
        reg_write(4'h0, 32'h4);
    endtask

    task automatic t_partial();
        int base;
        setup_desc(32'h170, 32'h110, 32'h20, 32'hA0, 6);
        mem[40] = 32'h0; mem[41] = 32'h0; mem[42] = 32'h7777_7777;
        reg_write(4'h4, 32'h170);
        base = log_n;
        reg_write(4'h0, 32'h1);
        wait_idle();
        check(log_n - base == 8, "R5 two words for 6 bytes", 32'(log_n - base), 8);
        check(mem[41] == mem[9], "R5 second word copied", mem[41], mem[9]);
        check(mem[42] == 32'h7777_7777, "R5 third word untouched", mem[42], 32'h7777_7777);
    endtask

    task automatic t_desc_lock();
        logic [31:0] s;
        setup_desc(32'h180, 32'h110, 32'h20, 32'h1C0, 32);
        reg_write(4'h4, 32'h180);
        reg_write(4'h0, 32'h1);
        reg_write(4'h4, 32'h40);
        reg_read(4'h0, s);
        check(s[0] == 1'b1, "R10 still active during write", s, 1);
        reg_read(4'h4, s);
        check(s == 32'h180, "R10 desc address kept while active", s, 32'h180);
        wait_idle();
        reg_read(4'h4, s);
        check(s == 32'h180, "R10 desc address after finish", s, 32'h180);
        check(mem[112] == mem[8], "R10 transfer used original descriptor", mem[112], mem[8]);
        check(hs_bad == 0, "R11 request held until ack", 32'(hs_bad), 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'(i) * 32'h0101_0101;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inc_copy();
        t_fixed();
        t_zero_len();
        t_partial();
        t_desc_lock();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule